// File: doc/BRIEF.md
# M12 Stuff-Aware T2 Demultiplexer

This block takes a T2 bit stream that an upstream frame detector has already aligned. With each bit it receives that bit's position: the subframe index, the block index within the subframe, and the bit index within the block. Bit index 0 is the block's overhead bit. Indices 1 to 48 are information bits.

The block deals the information bits out to four T1 tributaries in strict rotation. It undoes the line inversion that tributaries 2 and 4 carry in the T2 stream. From the three C bits of each subframe it decides whether that subframe's tributary was stuffed. When it was, the single stuff bit in the subframe's last block is dropped.

Each tributary leaves as a data bit plus a one-cycle valid strobe, ready for an external elastic store. The same C-bit pattern also carries a per-tributary loopback command. The block collects these commands and presents them as a set that changes only at M-frame boundaries.

Top module: `m12_demux`

## Requirements
- R1: An information bit with position index p (1..48) goes to tributary index (p-1) mod 4, where index 0 is tributary 1. Its valid strobe and data appear on the outputs one clock after the input cycle.
- R2: Tributary indices 1 and 3 (tributaries 2 and 4) are output inverted relative to the input bit. Indices 0 and 2 are output unchanged.
- R3: An overhead bit (position index 0), or a cycle with `in_valid` low, raises no valid strobe one clock later.
- R4: Within a subframe, the C bits are the overhead bits of blocks 1, 3 and 4, in that order. The stuff decision for the subframe is the majority of the three, with 1 meaning stuffed. This also holds when the three bits form the loopback pattern.
- R5: In subframe s (0..3), the stuff opportunity is block 5, position index s+1, which belongs to tributary index s. If the subframe's decision is stuffed, that bit raises no valid strobe. Otherwise it is output as normal data.
- R6: A subframe whose C bits satisfy C1 = C2 and C3 ≠ C1 requests loopback for the tributary whose index equals the subframe index. Every other pattern clears that request.
- R7: `loop_req` changes only one clock after the last bit of an M-frame (subframe 3, block 5, position 48). It then takes the requests decoded in that M-frame, and holds that value until the next such boundary.
- R8: While reset is asserted and right after it, all valid strobes, all data bits and `loop_req` are 0, and every subframe is treated as not stuffed until its C bits have been received.
- R9: At most one tributary valid strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input bit present this cycle |
| in_bit | input | 1 | T2 bit |
| in_sub | input | 2 | Subframe index 0..3 |
| in_blk | input | 3 | Block index 0..5 within the subframe |
| in_pos | input | 6 | Bit index in the block: 0 is the overhead bit, 1..48 are information bits |
| trib_data | output | 4 | Recovered data bit per tributary, meaningful when its strobe is high |
| trib_vld | output | 4 | One-cycle valid strobe per tributary |
| loop_req | output | 4 | Loopback request per tributary, updated once per M-frame |

## Verification
A lane index that slips by one shows up on the very next information bit, as a strobe on the wrong tributary or as a data bit with the wrong polarity. A stuff flag stored against the wrong subframe stays invisible until that subframe's stuff block. Then, within one clock, it either drops a genuine data bit or passes a stuff bit. So the bench varies the C-bit pattern of every subframe from frame to frame and compares all strobes on every clock. Corrupted loopback state can only reach the ports at an M-frame boundary, so several consecutive frames with different loopback patterns are run.

// File: rtl/m12_demux_pkg.sv
package m12_demux_pkg;

  localparam int unsigned DEF_NUM_TRIB     = 4;
  localparam int unsigned DEF_BLK_PER_SUB  = 6;
  localparam int unsigned DEF_INFO_PER_BLK = 48;

  // Overhead slots that carry the C bits, in decode order
  localparam int unsigned CB1_SLOT = 1;
  localparam int unsigned CB2_SLOT = 3;
  localparam int unsigned CB3_SLOT = 4;

  function automatic logic m12_maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic m12_loop_pat(input logic a, input logic b, input logic c);
    return (a == b) && (c != a);
  endfunction

endpackage

// File: rtl/m12_cbit_decoder.sv
module m12_cbit_decoder
  import m12_demux_pkg::*;
#(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned SUB_W   = 2,
  parameter int unsigned BLK_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovh_en,
  input  logic               ovh_bit,
  input  logic [SUB_W-1:0]   sub,
  input  logic [BLK_W-1:0]   blk,
  output logic [NUM_SUB-1:0] stuff_flag,
  output logic [NUM_SUB-1:0] lb_flag
);

  logic               c1_q, c1_d;
  logic               c2_q, c2_d;
  logic [NUM_SUB-1:0] stuff_q, stuff_d;
  logic [NUM_SUB-1:0] lb_q, lb_d;
  logic               at_c1, at_c2, at_c3;

  assign at_c1 = ovh_en && (blk == BLK_W'(CB1_SLOT));
  assign at_c2 = ovh_en && (blk == BLK_W'(CB2_SLOT));
  assign at_c3 = ovh_en && (blk == BLK_W'(CB3_SLOT));

  always_comb begin
    c1_d    = c1_q;
    c2_d    = c2_q;
    stuff_d = stuff_q;
    lb_d    = lb_q;
    if (at_c1) c1_d = ovh_bit;
    if (at_c2) c2_d = ovh_bit;
    if (at_c3) begin
      stuff_d[sub] = m12_maj3(c1_q, c2_q, ovh_bit);
      lb_d[sub]    = m12_loop_pat(c1_q, c2_q, ovh_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q    <= 1'b0;
      c2_q    <= 1'b0;
      stuff_q <= '0;
      lb_q    <= '0;
    end else if (ovh_en) begin
      c1_q    <= c1_d;
      c2_q    <= c2_d;
      stuff_q <= stuff_d;
      lb_q    <= lb_d;
    end
  end

  assign stuff_flag = stuff_q;
  assign lb_flag    = lb_q;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_chk
    // R4: unanimous ones always decode as stuffed
    a_r4_all_ones_stuff: assert property (@(posedge clk) disable iff (!rst_n)
      (at_c3 && sub == SUB_W'(s) && c1_q && c2_q && ovh_bit) |=> stuff_q[s]);
    // R4: unanimous zeros never decode as stuffed
    a_r4_all_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (at_c3 && sub == SUB_W'(s) && !c1_q && !c2_q && !ovh_bit) |=> !stuff_q[s]);
    // R6: loopback pattern raises the pending request
    a_r6_loop_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      (at_c3 && sub == SUB_W'(s) && (c1_q == c2_q) && (ovh_bit != c1_q)) |=> lb_q[s]);
  end

endmodule

// File: rtl/m12_lane_splitter.sv
module m12_lane_splitter #(
  parameter int unsigned NUM_TRIB   = 4,
  parameter int unsigned SUB_W      = 2,
  parameter int unsigned BLK_W      = 3,
  parameter int unsigned POS_W      = 6,
  parameter int unsigned STUFF_BLK  = 5,
  parameter logic [NUM_TRIB-1:0] INV_MASK = 4'b1010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                info_en,
  input  logic                info_bit,
  input  logic [SUB_W-1:0]    sub,
  input  logic [BLK_W-1:0]    blk,
  input  logic [POS_W-1:0]    pos,
  input  logic [NUM_TRIB-1:0] stuff_flag,
  output logic [NUM_TRIB-1:0] data,
  output logic [NUM_TRIB-1:0] vld
);

  localparam int unsigned LANE_W = (NUM_TRIB > 1) ? $clog2(NUM_TRIB) : 1;

  logic [POS_W-1:0]    pos_m1;
  logic [LANE_W-1:0]   lane;
  logic                stuff_hit;
  logic                drop;
  logic [NUM_TRIB-1:0] data_q, data_d;
  logic [NUM_TRIB-1:0] vld_q, vld_d;

  assign pos_m1    = pos - POS_W'(1);
  assign lane      = LANE_W'(pos_m1 % POS_W'(NUM_TRIB));
  assign stuff_hit = (blk == BLK_W'(STUFF_BLK)) && (pos == (POS_W'(sub) + POS_W'(1)));
  assign drop      = stuff_hit && stuff_flag[sub];

  for (genvar i = 0; i < NUM_TRIB; i++) begin : g_lane
    logic sel;
    assign sel = info_en && (lane == LANE_W'(i));
    always_comb begin
      data_d[i] = data_q[i];
      vld_d[i]  = 1'b0;
      if (sel) begin
        data_d[i] = info_bit ^ INV_MASK[i];
        vld_d[i]  = !drop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= '0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign data = data_q;
  assign vld  = vld_q;

  // R9: never two tributaries in the same cycle
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vld_q));
  // R3: no information bit in, no strobe out
  a_r3_quiet_without_info: assert property (@(posedge clk) disable iff (!rst_n)
    !info_en |=> (vld_q == '0));
  // R5: a decoded stuff bit is swallowed
  a_r5_stuff_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (info_en && stuff_hit && stuff_flag[sub]) |=> (vld_q == '0));
  // R5: an unstuffed opportunity still carries data
  a_r5_opportunity_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (info_en && stuff_hit && !stuff_flag[sub]) |=> ($countones(vld_q) == 1));

endmodule

// File: rtl/m12_loop_hold.sv
module m12_loop_hold #(
  parameter int unsigned NUM_TRIB = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic [NUM_TRIB-1:0] lb_pending,
  output logic [NUM_TRIB-1:0] loop_req
);

  logic [NUM_TRIB-1:0] req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (frame_end) req_d = lb_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_q <= '0;
    else if (frame_end) req_q <= req_d;
  end

  assign loop_req = req_q;

  // R7: request set only moves at an M-frame boundary
  a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(req_q));
  // R7: at the boundary the set follows the pending requests
  a_r7_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (req_q == $past(lb_pending)));

endmodule

// File: rtl/m12_demux.sv
module m12_demux
  import m12_demux_pkg::*;
#(
  parameter int unsigned NUM_TRIB     = DEF_NUM_TRIB,
  parameter int unsigned BLK_PER_SUB  = DEF_BLK_PER_SUB,
  parameter int unsigned INFO_PER_BLK = DEF_INFO_PER_BLK
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic                                  in_bit,
  input  logic [$clog2(NUM_TRIB)-1:0]           in_sub,
  input  logic [$clog2(BLK_PER_SUB)-1:0]        in_blk,
  input  logic [$clog2(INFO_PER_BLK+1)-1:0]     in_pos,
  output logic [NUM_TRIB-1:0]                   trib_data,
  output logic [NUM_TRIB-1:0]                   trib_vld,
  output logic [NUM_TRIB-1:0]                   loop_req
);

  localparam int unsigned SUB_W     = $clog2(NUM_TRIB);
  localparam int unsigned BLK_W     = $clog2(BLK_PER_SUB);
  localparam int unsigned POS_W     = $clog2(INFO_PER_BLK + 1);
  localparam int unsigned STUFF_BLK = BLK_PER_SUB - 1;
  localparam logic [NUM_TRIB-1:0] INV_MASK = {(NUM_TRIB/2){2'b10}};

  logic                ovh_en;
  logic                info_en;
  logic                frame_end;
  logic [NUM_TRIB-1:0] stuff_flag;
  logic [NUM_TRIB-1:0] lb_flag;

  assign ovh_en    = in_valid && (in_pos == '0);
  assign info_en   = in_valid && (in_pos != '0);
  assign frame_end = in_valid && (in_sub == SUB_W'(NUM_TRIB - 1))
                     && (in_blk == BLK_W'(STUFF_BLK))
                     && (in_pos == POS_W'(INFO_PER_BLK));

  m12_cbit_decoder #(
    .NUM_SUB (NUM_TRIB),
    .SUB_W   (SUB_W),
    .BLK_W   (BLK_W)
  ) u_cdec (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovh_en     (ovh_en),
    .ovh_bit    (in_bit),
    .sub        (in_sub),
    .blk        (in_blk),
    .stuff_flag (stuff_flag),
    .lb_flag    (lb_flag)
  );

  m12_lane_splitter #(
    .NUM_TRIB  (NUM_TRIB),
    .SUB_W     (SUB_W),
    .BLK_W     (BLK_W),
    .POS_W     (POS_W),
    .STUFF_BLK (STUFF_BLK),
    .INV_MASK  (INV_MASK)
  ) u_split (
    .clk        (clk),
    .rst_n      (rst_n),
    .info_en    (info_en),
    .info_bit   (in_bit),
    .sub        (in_sub),
    .blk        (in_blk),
    .pos        (in_pos),
    .stuff_flag (stuff_flag),
    .data       (trib_data),
    .vld        (trib_vld)
  );

  m12_loop_hold #(
    .NUM_TRIB (NUM_TRIB)
  ) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .lb_pending (lb_flag),
    .loop_req   (loop_req)
  );

endmodule

// File: tb/m12_demux_bench.sv
`timescale 1ns/1ps
module m12_demux_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_bit;
  logic [1:0] in_sub;
  logic [2:0] in_blk;
  logic [5:0] in_pos;
  logic [3:0] trib_data, trib_vld, loop_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural reference state
  int  c1m, c2m;
  int  stuffm[4];
  int  lbm[4];
  logic [3:0] exp_vld, exp_data, exp_loop;
  string exp_tag[4];

  always #2 clk = ~clk;

  m12_demux u_m12_demux (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_bit (in_bit),
    .in_sub (in_sub), .in_blk (in_blk), .in_pos (in_pos),
    .trib_data (trib_data), .trib_vld (trib_vld), .loop_req (loop_req)
  );

  task automatic compare();
    n_cmp++;
    if ($countones(trib_vld) > 1) begin
      n_bad++;
      $display("FAIL R9 strobes act=%b exp=at most one", trib_vld);
    end
    for (int i = 0; i < 4; i++) begin
      n_cmp++;
      if (trib_vld[i] !== exp_vld[i]) begin
        n_bad++;
        $display("FAIL %s vld lane %0d act=%b exp=%b", exp_tag[i], i, trib_vld[i], exp_vld[i]);
      end else if (exp_vld[i]) begin
        n_cmp++;
        if (trib_data[i] !== exp_data[i]) begin
          n_bad++;
          $display("FAIL %s data lane %0d act=%b exp=%b",
                   (i % 2 == 1) ? "R2" : "R1", i, trib_data[i], exp_data[i]);
        end
      end
    end
    n_cmp++;
    if (loop_req !== exp_loop) begin
      n_bad++;
      $display("FAIL R6/R7 loop_req act=%b exp=%b", loop_req, exp_loop);
    end
  endtask

  // One bit time: check the results of the previous input, then drive and model the next
  task automatic step(input bit v, input bit b, input int s, input int k, input int p);
    @(negedge clk);
    compare();
    in_valid = v; in_bit = b;
    in_sub = 2'(s); in_blk = 3'(k); in_pos = 6'(p);
    exp_vld = '0;
    for (int i = 0; i < 4; i++) exp_tag[i] = v ? "R1" : "R3";
    if (v && p == 0) begin
      for (int i = 0; i < 4; i++) exp_tag[i] = "R3";
      if (k == 1) c1m = b;
      if (k == 3) c2m = b;
      if (k == 4) begin
        stuffm[s] = (c1m + c2m + int'(b)) >= 2;   // R4 majority
        lbm[s]    = (c1m == c2m) && (int'(b) != c1m); // R6 pattern
      end
    end
    if (v && p > 0) begin
      int lane;
      lane = (p - 1) % 4;
      if (k == 5 && p == s + 1) begin
        exp_tag[lane] = "R4/R5";
        exp_vld[lane] = (stuffm[s] == 0);
      end else begin
        exp_vld[lane] = 1'b1;
      end
      exp_data[lane] = b ^ (lane % 2 == 1);
    end
    if (v && s == 3 && k == 5 && p == 48)
      for (int i = 0; i < 4; i++) exp_loop[i] = (lbm[i] != 0);
  endtask

  function automatic int cpat(input int f, input int s);
    return (f * 3 + s * 5 + 1) % 8;
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 0; in_bit = 0; in_sub = 0; in_blk = 0; in_pos = 0;
    c1m = 0; c2m = 0; exp_vld = '0; exp_data = '0; exp_loop = '0;
    for (int i = 0; i < 4; i++) begin stuffm[i] = 0; lbm[i] = 0; exp_tag[i] = "R8"; end
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    n_cmp++;
    if (trib_vld !== 4'b0 || trib_data !== 4'b0 || loop_req !== 4'b0) begin
      n_bad++;
      $display("FAIL R8 reset vld=%b data=%b loop=%b exp=0000", trib_vld, trib_data, loop_req);
    end
    rst_n = 1'b1;
    for (int f = 0; f < 7; f++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 6; k++) begin
          for (int p = 0; p < 49; p++) begin
            bit b;
            int pat;
            pat = cpat(f, s);
            if ($urandom_range(0, 15) == 0)   // R3: idle slot with junk position
              step(1'b0, 1'($urandom), $urandom_range(0, 3), 5, $urandom_range(0, 48));
            if (p == 0) begin
              case (k)
                1: b = pat[2];
                3: b = pat[1];
                4: b = pat[0];
                default: b = 1'($urandom);
              endcase
            end else begin
              b = 1'($urandom);
            end
            step(1'b1, b, s, k, p);
          end
        end
      end
    end
    step(1'b0, 1'b0, 0, 0, 0);
    step(1'b0, 1'b0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule